// File: doc/BRIEF.md
# UART Register Control Core

This block is the register-facing control core of a UART. A processor reaches it over a byte-wide bus that uses a word index. Through that bus it programs two mode bytes and a clock-select byte. It issues encoded commands, reads status flags, pulls received bytes from a small receive FIFO and pushes transmit bytes into a holding register. The holding register drains into a transmit FIFO. The bit-level serializer, the baud generator and interrupt logic live elsewhere. They consume the configuration outputs and the line-side byte handshake.

On the line side, transmit bytes leave through a valid/ready pair. Received bytes arrive as a one-cycle strobe. Each strobe carries the byte together with a parity-error flag, a framing-error flag and a break indication. Both mode bytes share one bus index, and an internal pointer selects between them. Read data is combinational. Any read side effect (FIFO pop, pointer advance) takes place at the clock edge that ends the access.

Top module: `uart_ctrl_regs`

## Requirements
- R1: Bus index 0 reaches mode byte 1 (`cfg_mode1`) on the first access after reset. Every access at index 0, read or write, moves the pointer to mode byte 2 (`cfg_mode2`), and it stays there. A command write whose bits 6:4 equal 1 returns the pointer to mode byte 1.
- R2: A read at index 1 returns the status byte: bit0 receive data ready, bit1 receive FIFO full, bit2 transmit holding register empty, bit3 holding register and transmit FIFO both empty, bit4 overrun, bit5 parity error, bit6 framing error, bit7 break change. After reset the status byte reads 0x0C.
- R3: Received bytes queue in a 4-entry FIFO and are read in arrival order at index 3. Each read removes one byte. A read of an empty FIFO returns 0x00.
- R4: A stored-byte strobe that arrives while the receive FIFO is full drops the byte and sets status bit4. The bit stays set until a command with bits 6:4 equal to 4, or a receiver reset.
- R5: Status bits 5 and 6 show the parity and framing flags of the byte at the FIFO head. Both read 0 when the FIFO is empty.
- R6: Each accepted strobe compares its break flag with the flag of the previous accepted strobe, which starts at 0. A difference sets status bit7, and a command with bits 6:4 equal to 5 clears it. A strobe whose break flag is set stores no byte.
- R7: Command bit0 turns the receiver on and bit1 turns it off. Bit2 turns the transmitter on and bit3 turns it off. If both bits of one direction are set, off wins. Strobes that arrive while the receiver is off are ignored.
- R8: A command with bits 6:4 equal to 2 empties the receive FIFO, turns the receiver off and clears overrun.
- R9: A command with bits 6:4 equal to 3 empties the holding register and the transmit FIFO, turns the transmitter off and drops `tx_valid` in the next cycle.
- R10: A write at index 3 loads the holding register only when status bit2 is 1; otherwise the byte is discarded. The holding register moves into the 2-entry transmit FIFO. Bytes leave in write order, and an offered byte holds `tx_valid` and `tx_data` steady until `tx_ready`.
- R11: Turning the transmitter off lets the byte already on offer complete its handshake. After that, no further byte is offered until the transmitter is turned on again.
- R12: A write at index 1 loads `cfg_clksel` without changing what index 1 reads. Reads at index 2 and at indices 4 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_word | input | 3 | Register index (byte offset divided by 4) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| tx_data | output | 8 | Byte offered to the serializer |
| tx_valid | output | 1 | Transmit byte on offer |
| tx_ready | input | 1 | Serializer takes the byte |
| rx_stb | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_perr | input | 1 | Parity error for this byte |
| rx_ferr | input | 1 | Framing error for this byte |
| rx_brk | input | 1 | Break condition on the line |
| cfg_mode1 | output | 8 | Mode byte 1 |
| cfg_mode2 | output | 8 | Mode byte 2 |
| cfg_clksel | output | 8 | Clock-select byte |
| rx_on | output | 1 | Receiver enabled |
| tx_on | output | 1 | Transmitter enabled |

## Verification
The properties assume a serializer that may hold `tx_ready` low for any number of cycles and a bus master that issues at most one access per cycle. They also assume that status reads are only meaningful while `bus_en` is high at index 1. The stimulus drives every bus access and every receive strobe for exactly one cycle between falling edges. It keeps `tx_ready` low except for single-cycle acceptances, so every offered byte sits through a stall before it completes. The bench uses the status encodings and command codes stated in the requirements. Each transmit byte is accepted only after `tx_valid` has been seen high.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int unsigned DATA_W = 8;

  localparam logic [2:0] OFS_MODE = 3'd0;
  localparam logic [2:0] OFS_STAT = 3'd1;
  localparam logic [2:0] OFS_CMD  = 3'd2;
  localparam logic [2:0] OFS_BUF  = 3'd3;

  localparam logic [2:0] MISC_PTR    = 3'd1;
  localparam logic [2:0] MISC_RXRST  = 3'd2;
  localparam logic [2:0] MISC_TXRST  = 3'd3;
  localparam logic [2:0] MISC_ERRCLR = 3'd4;
  localparam logic [2:0] MISC_BRKCLR = 3'd5;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_clr;
  } cmd_t;
endpackage

// File: rtl/ucs_cmd_decode.sv
module ucs_cmd_decode
  import ucs_pkg::*;
(
  input  logic       strobe,
  input  logic [6:0] code,
  output cmd_t       act
);
  always_comb begin
    act = '0;
    if (strobe) begin
      act.rx_on  = code[0];
      act.rx_off = code[1];
      act.tx_on  = code[2];
      act.tx_off = code[3];
      case (code[6:4])
        MISC_PTR:    act.ptr_rst = 1'b1;
        MISC_RXRST:  act.rx_rst  = 1'b1;
        MISC_TXRST:  act.tx_rst  = 1'b1;
        MISC_ERRCLR: act.err_clr = 1'b1;
        MISC_BRKCLR: act.brk_clr = 1'b1;
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/ucs_fifo.sv
module ucs_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLCNT = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULLCNT);
  assign do_push = push & ~full & ~flush;
  assign do_pop  = pop & ~empty & ~flush;
  assign dout    = mem[rd_q];

  always_comb begin
    rd_d  = rd_q;
    wr_d  = wr_q;
    cnt_d = cnt_q;
    if (flush) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wr_d = step(wr_q);
      if (do_pop)  rd_d = step(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/uart_ctrl_regs.sv
module uart_ctrl_regs
  import ucs_pkg::*;
#(
  parameter int unsigned RX_DEPTH = 4,
  parameter int unsigned TX_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_en,
  input  logic        bus_wr,
  input  logic [2:0]  bus_word,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [7:0]  tx_data,
  output logic        tx_valid,
  input  logic        tx_ready,
  input  logic        rx_stb,
  input  logic [7:0]  rx_byte,
  input  logic        rx_perr,
  input  logic        rx_ferr,
  input  logic        rx_brk,
  output logic [7:0]  cfg_mode1,
  output logic [7:0]  cfg_mode2,
  output logic [7:0]  cfg_clksel,
  output logic        rx_on,
  output logic        tx_on
);
  localparam int unsigned RXW = DATA_W + 2;

  logic acc_mode, wr_csel, wr_cmd, wr_buf, rd_buf;
  cmd_t act;

  logic [7:0] mode1_q, mode1_d, mode2_q, mode2_d, csel_q, csel_d, hold_q, hold_d;
  logic ptr_q, ptr_d, rxen_q, rxen_d, txen_q, txen_d;
  logic ovr_q, ovr_d, brk_q, brk_d, brkchg_q, brkchg_d;
  logic hfull_q, hfull_d, launch_q, launch_d;

  logic rx_take, rx_store, rx_empty, rx_full;
  logic [RXW-1:0] rx_head;
  logic tx_empty, tx_full, tx_xfer, tx_pop, hold_load;
  logic [7:0] status;

  assign acc_mode = bus_en & (bus_word == OFS_MODE);
  assign wr_csel  = bus_en & bus_wr & (bus_word == OFS_STAT);
  assign wr_cmd   = bus_en & bus_wr & (bus_word == OFS_CMD);
  assign wr_buf   = bus_en & bus_wr & (bus_word == OFS_BUF);
  assign rd_buf   = bus_en & ~bus_wr & (bus_word == OFS_BUF);

  ucs_cmd_decode u_dec (.strobe(wr_cmd), .code(bus_wdata[6:0]), .act(act));

  // receive side
  assign rx_take  = rx_stb & rxen_q & ~act.rx_rst;
  assign rx_store = rx_take & ~rx_brk;

  ucs_fifo #(.WIDTH(RXW), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(act.rx_rst),
    .push(rx_store), .din({rx_perr, rx_ferr, rx_byte}),
    .pop(rd_buf), .dout(rx_head), .empty(rx_empty), .full(rx_full)
  );

  // transmit side
  assign hold_load = wr_buf & ~hfull_q;
  assign tx_xfer   = hfull_q & ~tx_full & ~act.tx_rst;
  assign tx_valid  = ~tx_empty & (txen_q | launch_q);
  assign tx_pop    = tx_valid & tx_ready;

  ucs_fifo #(.WIDTH(DATA_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(act.tx_rst),
    .push(tx_xfer), .din(hold_q),
    .pop(tx_pop), .dout(tx_data), .empty(tx_empty), .full(tx_full)
  );

  assign status = {brkchg_q,
                   rx_head[RXW-2] & ~rx_empty,
                   rx_head[RXW-1] & ~rx_empty,
                   ovr_q,
                   ~hfull_q & tx_empty,
                   ~hfull_q,
                   rx_full,
                   ~rx_empty};

  always_comb begin
    case (bus_word)
      OFS_MODE: bus_rdata = ptr_q ? mode2_q : mode1_q;
      OFS_STAT: bus_rdata = status;
      OFS_BUF:  bus_rdata = rx_empty ? 8'h00 : rx_head[DATA_W-1:0];
      default:  bus_rdata = 8'h00;
    endcase
  end

  always_comb begin
    mode1_d  = mode1_q;
    mode2_d  = mode2_q;
    csel_d   = csel_q;
    ptr_d    = ptr_q;
    rxen_d   = rxen_q;
    txen_d   = txen_q;
    ovr_d    = ovr_q;
    brk_d    = brk_q;
    brkchg_d = brkchg_q;
    hold_d   = hold_q;
    hfull_d  = hfull_q;
    launch_d = launch_q;

    if (acc_mode && bus_wr) begin
      if (ptr_q) mode2_d = bus_wdata;
      else       mode1_d = bus_wdata;
    end
    if (act.ptr_rst)   ptr_d = 1'b0;
    else if (acc_mode) ptr_d = 1'b1;
    if (wr_csel) csel_d = bus_wdata;

    if (act.rx_rst || act.rx_off) rxen_d = 1'b0;
    else if (act.rx_on)           rxen_d = 1'b1;
    if (act.tx_rst || act.tx_off) txen_d = 1'b0;
    else if (act.tx_on)           txen_d = 1'b1;

    if (act.rx_rst || act.err_clr) ovr_d = 1'b0;
    if (rx_store && rx_full)       ovr_d = 1'b1;

    if (act.brk_clr) brkchg_d = 1'b0;
    if (rx_take) begin
      brk_d = rx_brk;
      if (rx_brk != brk_q) brkchg_d = 1'b1;
    end

    if (act.tx_rst) begin
      hfull_d  = 1'b0;
      launch_d = 1'b0;
    end else begin
      if (hold_load) begin
        hold_d  = bus_wdata;
        hfull_d = 1'b1;
      end else if (tx_xfer) begin
        hfull_d = 1'b0;
      end
      if (tx_valid) launch_d = ~tx_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1_q  <= '0;
      mode2_q  <= '0;
      csel_q   <= '0;
      ptr_q    <= 1'b0;
      rxen_q   <= 1'b0;
      txen_q   <= 1'b0;
      ovr_q    <= 1'b0;
      brk_q    <= 1'b0;
      brkchg_q <= 1'b0;
      hold_q   <= '0;
      hfull_q  <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      mode1_q  <= mode1_d;
      mode2_q  <= mode2_d;
      csel_q   <= csel_d;
      ptr_q    <= ptr_d;
      rxen_q   <= rxen_d;
      txen_q   <= txen_d;
      ovr_q    <= ovr_d;
      brk_q    <= brk_d;
      brkchg_q <= brkchg_d;
      hold_q   <= hold_d;
      hfull_q  <= hfull_d;
      launch_q <= launch_d;
    end
  end

  assign cfg_mode1  = mode1_q;
  assign cfg_mode2  = mode2_q;
  assign cfg_clksel = csel_q;
  assign rx_on      = rxen_q;
  assign tx_on      = txen_q;
endmodule

// File: rtl/ucs_checker.sv
module ucs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_en,
  input logic       bus_wr,
  input logic [2:0] bus_word,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       rx_on,
  input logic       tx_on
);
  logic stat_rd, cmd_wr;
  assign stat_rd = bus_en & ~bus_wr & (bus_word == 3'd1);
  assign cmd_wr  = bus_en & bus_wr & (bus_word == 3'd2);

  // R2: an empty transmit path always has a free holding register
  a_r2_empty_implies_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && bus_rdata[3]) |-> bus_rdata[2]);

  // R3: a full receive FIFO always has data ready
  a_r3_full_implies_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && bus_rdata[1]) |-> bus_rdata[0]);

  // R5: error flags only with a byte at the head
  a_r5_flags_need_data: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (bus_rdata[5] || bus_rdata[6])) |-> bus_rdata[0]);

  // R7: a disable bit always turns the receiver off
  a_r7_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[1]) |=> !rx_on);

  // R8: receiver reset turns the receiver off
  a_r8_rx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[6:4] == 3'd2) |=> !rx_on);

  // R9: transmitter reset withdraws the offer and disables
  a_r9_tx_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && bus_wdata[6:4] == 3'd3) |=> (!tx_valid && !tx_on));

  // R10: an offered byte stays until taken
  a_r10_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !(cmd_wr && bus_wdata[6:4] == 3'd3))
      |=> (tx_valid && $stable(tx_data)));

  // R11: a disabled idle transmitter offers nothing new
  a_r11_no_new_offer: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_on && !tx_valid && !(cmd_wr && bus_wdata[2])) |=> !tx_valid);
endmodule

bind uart_ctrl_regs ucs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
  .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .rx_on(rx_on), .tx_on(tx_on)
);

// File: tb/uart_ctrl_regs_test.sv
module uart_ctrl_regs_test;
  localparam int CLK_PERIOD = 10;

  logic clk, rst_n;
  logic bus_en, bus_wr, tx_ready, rx_stb, rx_perr, rx_ferr, rx_brk;
  logic [2:0] bus_word;
  logic [7:0] bus_wdata, bus_rdata, tx_data, rx_byte;
  logic tx_valid, rx_on, tx_on;
  logic [7:0] cfg_mode1, cfg_mode2, cfg_clksel;

  int n_chk = 0;
  int n_bad = 0;

  uart_ctrl_regs uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_stb(rx_stb), .rx_byte(rx_byte), .rx_perr(rx_perr),
    .rx_ferr(rx_ferr), .rx_brk(rx_brk),
    .cfg_mode1(cfg_mode1), .cfg_mode2(cfg_mode2), .cfg_clksel(cfg_clksel),
    .rx_on(rx_on), .tx_on(tx_on)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] w, input logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] w, output logic [7:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_wr = 1'b0; bus_word = w;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] w, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(w, v);
    check(tag, v, exp);
  endtask

  task automatic rx_send(input logic [7:0] b, input logic pe, input logic fe, input logic bk);
    @(negedge clk);
    rx_stb = 1'b1; rx_byte = b; rx_perr = pe; rx_ferr = fe; rx_brk = bk;
    @(negedge clk);
    rx_stb = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string tag);
    @(negedge clk);
    check({tag, " valid"}, {7'd0, tx_valid}, 8'h01);
    check({tag, " data"}, tx_data, exp);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R2 reset tx_valid", {7'd0, tx_valid}, 8'h00);
    check("R7 reset enables", {6'd0, rx_on, tx_on}, 8'h00);
    rd_chk(3'd1, 8'h0C, "R2 reset status");
  endtask

  task automatic t_mode;
    wr(3'd0, 8'h13);
    check("R1 first goes to mode1", cfg_mode1, 8'h13);
    wr(3'd0, 8'h07);
    check("R1 second goes to mode2", cfg_mode2, 8'h07);
    check("R1 mode1 kept", cfg_mode1, 8'h13);
    rd_chk(3'd0, 8'h07, "R1 pointer stays on mode2");
    wr(3'd2, 8'h10);
    rd_chk(3'd0, 8'h13, "R1 pointer reset to mode1");
    rd_chk(3'd0, 8'h07, "R1 read advances pointer");
    wr(3'd1, 8'hDD);
    check("R12 clock select", cfg_clksel, 8'hDD);
    rd_chk(3'd1, 8'h0C, "R12 index1 reads status");
    rd_chk(3'd2, 8'h00, "R12 command reads zero");
    rd_chk(3'd4, 8'h00, "R12 unmapped reads zero");
    rd_chk(3'd6, 8'h00, "R12 unmapped reads zero");
  endtask

  task automatic t_rx;
    wr(3'd2, 8'h01);
    check("R7 rx enable", {7'd0, rx_on}, 8'h01);
    rx_send(8'hA1, 1'b1, 1'b0, 1'b0);
    rx_send(8'hB2, 1'b0, 1'b1, 1'b0);
    rx_send(8'hC3, 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h2D, "R5 head parity flag");
    rx_send(8'hD4, 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h2F, "R3 fifo full");
    rx_send(8'hE5, 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h3F, "R4 overrun set");
    rd_chk(3'd3, 8'hA1, "R3 first byte");
    rd_chk(3'd1, 8'h5D, "R5 head framing flag");
    rd_chk(3'd3, 8'hB2, "R3 second byte");
    rd_chk(3'd1, 8'h1D, "R5 clean head");
    rd_chk(3'd3, 8'hC3, "R3 third byte");
    rd_chk(3'd3, 8'hD4, "R4 fourth byte, overrun byte dropped");
    rd_chk(3'd1, 8'h1C, "R4 overrun sticky");
    rd_chk(3'd3, 8'h00, "R3 empty read");
    wr(3'd2, 8'h40);
    rd_chk(3'd1, 8'h0C, "R4 error clear");
  endtask

  task automatic t_brk;
    rx_send(8'h99, 1'b0, 1'b0, 1'b1);
    rd_chk(3'd1, 8'h8C, "R6 break change, nothing stored");
    wr(3'd2, 8'h50);
    rd_chk(3'd1, 8'h0C, "R6 break change clear");
    rx_send(8'h55, 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h8D, "R6 break end is a change");
    rd_chk(3'd3, 8'h55, "R6 byte after break");
    wr(3'd2, 8'h50);
    rx_send(8'h66, 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h0D, "R6 no change without transition");
    rd_chk(3'd3, 8'h66, "R6 byte read");
  endtask

  task automatic t_rxctl;
    wr(3'd2, 8'h02);
    check("R7 rx disable", {7'd0, rx_on}, 8'h00);
    rx_send(8'h77, 1'b1, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h0C, "R7 disabled receiver ignores strobe");
    wr(3'd2, 8'h03);
    check("R7 off wins over on", {7'd0, rx_on}, 8'h00);
    wr(3'd2, 8'h01);
    for (int i = 1; i <= 5; i++) rx_send(8'(i), 1'b0, 1'b0, 1'b0);
    rd_chk(3'd1, 8'h1F, "R8 before receiver reset");
    wr(3'd2, 8'h20);
    check("R8 receiver off", {7'd0, rx_on}, 8'h00);
    rd_chk(3'd1, 8'h0C, "R8 fifo empty, overrun clear");
    rd_chk(3'd3, 8'h00, "R8 nothing to read");
  endtask

  task automatic t_tx;
    wr(3'd3, 8'h11);
    rd_chk(3'd1, 8'h04, "R2 ready but not empty");
    check("R10 nothing offered while off", {7'd0, tx_valid}, 8'h00);
    wr(3'd2, 8'h04);
    wr(3'd3, 8'h22);
    wr(3'd3, 8'h33);
    wr(3'd3, 8'h44);
    rd_chk(3'd1, 8'h00, "R10 holding full");
    tx_take(8'h11, "R10 order 1");
    tx_take(8'h22, "R10 order 2");
    tx_take(8'h33, "R10 order 3");
    @(negedge clk);
    check("R10 write while full discarded", {7'd0, tx_valid}, 8'h00);
    rd_chk(3'd1, 8'h0C, "R10 drained");
  endtask

  task automatic t_txctl;
    wr(3'd3, 8'h5A);
    wr(3'd3, 8'h6B);
    check("R10 offered", tx_data, 8'h5A);
    wr(3'd2, 8'h08);
    check("R11 offer survives disable", {7'd0, tx_valid}, 8'h01);
    tx_take(8'h5A, "R11 pending byte completes");
    @(negedge clk);
    check("R11 no further offer", {7'd0, tx_valid}, 8'h00);
    rd_chk(3'd1, 8'h04, "R11 byte waits in fifo");
    wr(3'd3, 8'h7C);
    wr(3'd2, 8'h30);
    check("R9 tx off", {7'd0, tx_on}, 8'h00);
    rd_chk(3'd1, 8'h0C, "R9 path emptied");
    wr(3'd2, 8'h04);
    @(negedge clk);
    check("R9 nothing left to offer", {7'd0, tx_valid}, 8'h00);
    wr(3'd3, 8'h8D);
    wr(3'd3, 8'h9E);
    wr(3'd2, 8'h30);
    check("R9 offer dropped", {7'd0, tx_valid}, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    bus_en = 1'b0; bus_wr = 1'b0; bus_word = '0; bus_wdata = '0;
    tx_ready = 1'b0; rx_stb = 1'b0; rx_byte = '0;
    rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode();
    t_rx();
    t_brk();
    t_rxctl();
    t_tx();
    t_txctl();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule